// File: doc/BRIEF.md
# Complementary Gate Command Generator with Dead Time

This block turns one pulse-width-modulated control bit into a pair of complementary gate commands for the two switches of a half bridge. A high PWM level selects the upper switch and a low level selects the lower switch. Every change of the selected side passes through a break-before-make gap. The gap is a number of clock cycles taken from an input setting, and during it both commands are off. An optional input filter can be switched on. It drops PWM excursions shorter than a fixed number of cycles, and every change that does pass is delayed by that number of cycles.

The commands are gated for safety. If the enable input is low, or the control-side supply is reported bad, both commands turn off in the same cycle. When operation is allowed again, the selected side comes back only after a full gap. A bad supply flag for one switch turns off only that switch's command, and the other side keeps following the PWM phase. A ready output shows that all three supply flags are good.

Top module: `cmpl_gate_drv`

## Requirements
- R1: Once settled, with PWM high `gate_hi`=1 and `gate_lo`=0; with PWM low `gate_hi`=0 and `gate_lo`=1 (1 means switch on).
- R2: `gate_hi` and `gate_lo` are never 1 in the same cycle, and a side never turns on in a cycle that follows one where the other side was on.
- R3: With the filter off, when `pwm_in` changes and is sampled at rising edge k, the side that was on turns off at edge k+1. The other side turns on at edge k+1+D, where D = `dead_cyc`, or 1 when `dead_cyc` is 0.
- R4: With `dg_sel`=1, a PWM change is taken only after it has been sampled GLITCH_CYC consecutive times (default 4). Shorter excursions leave the outputs unchanged, and accepted changes arrive GLITCH_CYC cycles later than in R3.
- R5: `en_in`=0 or `pwr_in_ok`=0 forces both commands to 0 in the same cycle, without waiting for a clock edge.
- R6: When enable and control power are both good again, the selected side turns on at the (D+1)-th rising edge that samples them good, counting the first one. The selected side follows the PWM level at that time.
- R7: `pwr_hi_ok`=0 forces only `gate_hi` to 0, and `pwr_lo_ok`=0 forces only `gate_lo` to 0. The other command keeps its normal R1/R3 behaviour.
- R8: `ready` is 1 exactly when `pwr_in_ok`, `pwr_hi_ok` and `pwr_lo_ok` are all 1.
- R9: If the PWM phase changes again before a gap ends, the gap restarts toward the newest phase and the abandoned side never turns on.
- R10: While `rst_n` is low, both commands are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | PWM control level, 1 selects the upper switch |
| en_in | input | 1 | Operation allowed when 1 |
| dead_cyc | input | DT_W | Break-before-make gap in cycles (0 treated as 1) |
| dg_sel | input | 1 | 1 enables the input glitch filter |
| pwr_in_ok | input | 1 | Control-side supply good |
| pwr_hi_ok | input | 1 | Upper-switch supply good |
| pwr_lo_ok | input | 1 | Lower-switch supply good |
| gate_hi | output | 1 | Upper-switch command |
| gate_lo | output | 1 | Lower-switch command |
| ready | output | 1 | All three supplies good |

## Verification
Both edge directions are swept over gap settings 0 through 5, with the filter on and with it off. This separates the release latency from the gap length, and it separates the zero-setting floor from the linear range. Pulses of GLITCH_CYC-1 and GLITCH_CYC cycles show the acceptance boundary of the filter. A PWM reversal in the middle of a gap shows whether the sequence restarts. The enable and control-power outages change the PWM during the outage, to show that recovery takes a full gap and follows the new phase. Every combination of the three supply flags is applied to check ready and the per-side masking.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

   typedef struct packed {
      logic hi;
      logic lo;
   } gate_pair_t;

   typedef enum logic [1:0] {
      SEQ_HOLD  = 2'd0,
      SEQ_GAP   = 2'd1,
      SEQ_DRIVE = 2'd2
   } seq_state_t;

endpackage

// File: rtl/cgd_glitch_filter.sv
module cgd_glitch_filter #(
   parameter int GLITCH_CYC   = 4,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic dg_sel,
   output logic phase
);
   localparam int CW = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC);

   if (GLITCH_CYC < 2) begin : g_bad_len
      $error("GLITCH_CYC must be at least 2");
   end

   logic raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= pwm_in;
   end

   if (HAS_DEGLITCH) begin : g_filter
      logic          filt_q;
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
         end else if (!dg_sel) begin
            filt_q <= raw_q;
            cnt_q  <= '0;
         end else if (raw_q == filt_q) begin
            cnt_q  <= '0;
         end else if (cnt_q == CW'(GLITCH_CYC - 1)) begin
            filt_q <= raw_q;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + CW'(1);
         end
      end

      assign phase = dg_sel ? filt_q : raw_q;

      AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(dg_sel) && (filt_q != $past(filt_q))) |-> ($past(cnt_q) == CW'(GLITCH_CYC - 1))); // R4
   end else begin : g_bypass
      logic unused_sel;
      assign unused_sel = dg_sel;
      assign phase      = raw_q;
   end

endmodule

// File: rtl/cgd_dead_seq.sv
module cgd_dead_seq
   import cgd_pkg::*;
#(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            allow,
   input  logic            phase,
   input  logic [DT_W-1:0] dead_cyc,
   output gate_pair_t      drv
);
   seq_state_t      state_q;
   logic            tgt_q;
   logic [DT_W-1:0] cnt_q;
   logic [DT_W-1:0] dt_eff;

   assign dt_eff = (dead_cyc == '0) ? DT_W'(1) : dead_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_HOLD;
         tgt_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (!allow) begin
         state_q <= SEQ_HOLD;
         tgt_q   <= phase;
         cnt_q   <= '0;
      end else if (phase != tgt_q) begin
         state_q <= SEQ_GAP;
         tgt_q   <= phase;
         cnt_q   <= DT_W'(1);
      end else begin
         unique case (state_q)
            SEQ_HOLD: begin
               state_q <= SEQ_GAP;
               cnt_q   <= DT_W'(1);
            end
            SEQ_GAP: begin
               if (cnt_q >= dt_eff) state_q <= SEQ_DRIVE;
               else                 cnt_q   <= cnt_q + DT_W'(1);
            end
            SEQ_DRIVE: state_q <= SEQ_DRIVE;
            default:   state_q <= SEQ_HOLD;
         endcase
      end
   end

   assign drv.hi = (state_q == SEQ_DRIVE) &&  tgt_q;
   assign drv.lo = (state_q == SEQ_DRIVE) && !tgt_q;

   AST_GAP_BEFORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == SEQ_DRIVE) |-> $past(!drv.hi && !drv.lo)); // R2
   AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == SEQ_DRIVE) |-> ($past(cnt_q) >= $past(dt_eff))); // R3
   AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !allow |=> (state_q == SEQ_HOLD)); // R5
   AST_RESTART_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (allow && (phase != tgt_q)) |=> ((state_q == SEQ_GAP) && (tgt_q == $past(phase)))); // R9

endmodule

// File: rtl/cgd_safety_gate.sv
module cgd_safety_gate
   import cgd_pkg::*;
(
   input  logic       en_in,
   input  logic       pwr_in_ok,
   input  logic       pwr_hi_ok,
   input  logic       pwr_lo_ok,
   input  gate_pair_t drv,
   output logic       allow,
   output logic       gate_hi,
   output logic       gate_lo,
   output logic       ready
);
   assign allow   = en_in && pwr_in_ok;
   assign gate_hi = drv.hi && allow && pwr_hi_ok;
   assign gate_lo = drv.lo && allow && pwr_lo_ok;
   assign ready   = pwr_in_ok && pwr_hi_ok && pwr_lo_ok;

endmodule

// File: rtl/cmpl_gate_drv.sv
module cmpl_gate_drv
   import cgd_pkg::*;
#(
   parameter int DT_W         = 8,
   parameter int GLITCH_CYC   = 4,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwm_in,
   input  logic            en_in,
   input  logic [DT_W-1:0] dead_cyc,
   input  logic            dg_sel,
   input  logic            pwr_in_ok,
   input  logic            pwr_hi_ok,
   input  logic            pwr_lo_ok,
   output logic            gate_hi,
   output logic            gate_lo,
   output logic            ready
);
   if (DT_W < 2) begin : g_bad_width
      $error("DT_W must be at least 2");
   end

   logic       phase;
   logic       allow;
   gate_pair_t drv;

   cgd_glitch_filter #(
      .GLITCH_CYC   (GLITCH_CYC),
      .HAS_DEGLITCH (HAS_DEGLITCH)
   ) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwm_in (pwm_in),
      .dg_sel (dg_sel),
      .phase  (phase)
   );

   cgd_dead_seq #(
      .DT_W (DT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .allow    (allow),
      .phase    (phase),
      .dead_cyc (dead_cyc),
      .drv      (drv)
   );

   cgd_safety_gate u_gate (
      .en_in     (en_in),
      .pwr_in_ok (pwr_in_ok),
      .pwr_hi_ok (pwr_hi_ok),
      .pwr_lo_ok (pwr_lo_ok),
      .drv       (drv),
      .allow     (allow),
      .gate_hi   (gate_hi),
      .gate_lo   (gate_lo),
      .ready     (ready)
   );

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo)); // R2
   AST_SIDE_FAULT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_hi_ok |-> !gate_hi); // R7

endmodule

// File: tb/sim_cmpl_gate_drv.sv
`timescale 1ns/1ps
module sim_cmpl_gate_drv;
   localparam int G    = 4;
   localparam int DT_W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            pwm_in = 1'b0, en_in = 1'b1, dg_sel = 1'b0;
   logic            pwr_in_ok = 1'b1, pwr_hi_ok = 1'b1, pwr_lo_ok = 1'b1;
   logic [DT_W-1:0] dead_cyc = '0;
   logic            gate_hi, gate_lo, ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   cmpl_gate_drv #(.DT_W(DT_W), .GLITCH_CYC(G), .HAS_DEGLITCH(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .en_in(en_in),
      .dead_cyc(dead_cyc), .dg_sel(dg_sel), .pwr_in_ok(pwr_in_ok),
      .pwr_hi_ok(pwr_hi_ok), .pwr_lo_ok(pwr_lo_ok),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .ready(ready));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2: per-cycle overlap monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (gate_hi && gate_lo) begin
            fails++;
            $display("FAIL R2 overlap actual=1 expected=0");
         end
      end
   end

   function automatic int eff(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   // Step the PWM; measure release and turn-on in negedges (R1, R3, R4)
   task automatic step(input bit v, input int d, input bit dg);
      int rel = -1;
      int on  = -1;
      int exp_rel = 2 + (dg ? G : 0);
      int exp_on  = exp_rel + eff(d);
      pwm_in = v;
      for (int m = 1; m <= 40; m++) begin
         @(negedge clk);
         if (rel < 0 && !(v ? gate_lo : gate_hi)) rel = m;
         if (on  < 0 &&  (v ? gate_hi : gate_lo)) on  = m;
      end
      chk(rel == exp_rel, dg ? "R4 release" : "R3 release", rel, exp_rel);
      chk(on == exp_on, dg ? "R4 turn-on" : "R3 turn-on", on, exp_on);
      chk((gate_hi == v) && (gate_lo == !v), "R1 settled", {gate_hi, gate_lo}, {v, !v});
   endtask

   task automatic pulse(input int p, input bit expect_pass);
      int lo_drop = 0;
      int hi_seen = 0;
      pwm_in = 1'b1;
      for (int m = 1; m <= 40; m++) begin
         if (m == p + 1) pwm_in = 1'b0;
         @(negedge clk);
         if (!gate_lo) lo_drop = 1;
         if (gate_hi)  hi_seen = 1;
      end
      chk(lo_drop == int'(expect_pass), "R4 pulse lo", lo_drop, int'(expect_pass));
      chk(hi_seen == int'(expect_pass), "R4 pulse hi", hi_seen, int'(expect_pass));
      chk(gate_lo == 1'b1, "R4 back low", gate_lo, 1);
   endtask

   initial begin
      // R10: reset
      repeat (3) @(negedge clk);
      chk(!gate_hi && !gate_lo, "R10 reset", {gate_hi, gate_lo}, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(gate_lo && !gate_hi, "R1 after reset", {gate_hi, gate_lo}, 1);

      // R3/R4 sweep
      for (int dg = 0; dg <= 1; dg++) begin
         for (int d = 0; d <= 5; d++) begin
            dg_sel   = dg[0];
            dead_cyc = DT_W'(d);
            step(1'b1, d, dg[0]);
            step(1'b0, d, dg[0]);
         end
      end

      // R4 filter boundary
      dg_sel = 1'b1; dead_cyc = 8'd1;
      repeat (10) @(negedge clk);
      pulse(G - 1, 1'b0);
      pulse(G, 1'b1);

      // R9 reversal inside the gap
      dg_sel = 1'b0; dead_cyc = 8'd4;
      repeat (10) @(negedge clk);
      begin
         int low_at = -1;
         int back_at = -1;
         int hi_seen = 0;
         pwm_in = 1'b1;
         for (int m = 1; m <= 30; m++) begin
            @(negedge clk);
            if (gate_hi) hi_seen = 1;
            if (low_at < 0 && !gate_lo) low_at = m;
            if (low_at > 0 && back_at < 0 && gate_lo) back_at = m;
            if (m == 2) pwm_in = 1'b0;
         end
         chk(hi_seen == 0, "R9 abandoned side", hi_seen, 0);
         chk(low_at == 2, "R9 release", low_at, 2);
         chk(back_at == 8, "R9 restart", back_at, 8);
      end

      // R5/R6 enable
      dead_cyc = 8'd3;
      pwm_in = 1'b1;
      repeat (15) @(negedge clk);
      en_in = 1'b0;
      #1;
      chk(!gate_hi && !gate_lo, "R5 enable off", {gate_hi, gate_lo}, 0);
      repeat (5) @(negedge clk);
      chk(!gate_hi && !gate_lo, "R5 enable held", {gate_hi, gate_lo}, 0);
      begin
         int on = -1;
         en_in = 1'b1;
         for (int m = 1; m <= 20; m++) begin
            @(negedge clk);
            if (on < 0 && gate_hi) on = m;
         end
         chk(on == 4, "R6 enable resume", on, 4);
      end

      // R5/R6 control power, PWM changed during outage
      pwr_in_ok = 1'b0;
      #1;
      chk(!gate_hi && !gate_lo, "R5 power off", {gate_hi, gate_lo}, 0);
      repeat (2) @(negedge clk);
      pwm_in = 1'b0;
      repeat (5) @(negedge clk);
      chk(!gate_hi && !gate_lo, "R5 power held", {gate_hi, gate_lo}, 0);
      begin
         int on = -1;
         int hi_seen = 0;
         pwr_in_ok = 1'b1;
         for (int m = 1; m <= 20; m++) begin
            @(negedge clk);
            if (on < 0 && gate_lo) on = m;
            if (gate_hi) hi_seen = 1;
         end
         chk(on == 4, "R6 power resume", on, 4);
         chk(hi_seen == 0, "R6 follows new phase", hi_seen, 0);
      end

      // R7 upper-side supply fault
      dead_cyc = 8'd2;
      pwm_in = 1'b1;
      repeat (12) @(negedge clk);
      pwr_hi_ok = 1'b0;
      #1;
      chk(!gate_hi, "R7 hi masked", gate_hi, 0);
      chk(!ready, "R8 fault ready", ready, 0);
      begin
         int on = -1;
         int hi_seen = 0;
         pwm_in = 1'b0;
         for (int m = 1; m <= 20; m++) begin
            @(negedge clk);
            if (on < 0 && gate_lo) on = m;
            if (gate_hi) hi_seen = 1;
         end
         chk(on == 4, "R7 lo still switches", on, 4);
         pwm_in = 1'b1;
         for (int m = 1; m <= 20; m++) begin
            @(negedge clk);
            if (gate_hi) hi_seen = 1;
         end
         chk(hi_seen == 0, "R7 hi stays off", hi_seen, 0);
         chk(!gate_lo, "R7 lo follows phase", gate_lo, 0);
      end
      pwr_hi_ok = 1'b1;
      #1;
      chk(gate_hi, "R7 hi returns", gate_hi, 1);

      // R8 exhaustive flags
      for (int f = 0; f < 8; f++) begin
         @(negedge clk);
         {pwr_in_ok, pwr_hi_ok, pwr_lo_ok} = f[2:0];
         #1;
         chk(ready == (f == 7), "R8 ready", ready, int'(f == 7));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule